// File: doc/BRIEF.md
# Symmetric Bit-Serial Low-Pass FIR Filter (32 taps, partitioned tables)

This block is a 32-tap linear-phase low-pass FIR filter that uses no multipliers. The coefficient set is even-symmetric, so the block first adds each sample to its mirror image in the delay line. That leaves sixteen signed words, each one bit wider than a sample. These words are then consumed one bit-plane per clock, least significant bit first. In each step the current bits of four neighbouring words address one of four small tables of precomputed coefficient sums. The four table outputs are added, and the result is weighted by its bit position and accumulated. The sign plane is subtracted rather than added.

Samples arrive on a valid-qualified input and are accepted only while the engine is idle. Each accepted sample produces exactly one result pulse on the output. The pre-add, table-sum and accumulate sections are separated by registers. The result therefore appears a fixed number of cycles after acceptance, and a new sample can be taken in the same cycle the previous result is presented.

Top module: `dafir_top`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, and the 32-sample history holds zeros. The first outputs therefore see only the samples accepted since reset.
- R2: For each accepted sample, out_data equals the sum over k = 0..31 of h(k)·x(n−k). Here x(n) is the sample just accepted, and samples are DW-bit two's complement (DW = 12 by default). out_data is a signed (2·DW+5)-bit value, 29 bits by default.
- R3: The coefficients are h(0..15) = 4, 9, 13, 12, 5, −10, 30, −48, −55, −39, 3, 72, 158, 247, 321, 362, with h(31−k) = h(k). An isolated unit impulse therefore yields these 32 values in tap order, followed by zeros.
- R4: out_valid is high for exactly one cycle per accepted sample. It is observed high in the cycle after the DW+3-th rising edge counted from the accepting edge (15 edges later with the default width), and it stays low between those pulses.
- R5: A sample is accepted on a rising edge where in_valid is 1 and the engine is idle. From the accepting edge until the edge that raises out_valid, in_valid is ignored: it changes neither the pending result nor the history used by later results.
- R6: The most negative sample (−2^(DW−1)) is handled exactly, including mirrored pairs whose pre-added word reaches −2^DW. This works only because the sign bit-plane is subtracted.
- R7: The most positive sample (2^(DW−1)−1), held constant, produces the full-scale positive result exactly.
- R8: The engine is idle again in the cycle where out_valid is high. A sample presented in that cycle is accepted, so samples spaced DW+4 cycles apart (16 by default) are all processed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present on in_data |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 2·DW+5 | Signed filtered result |

## Verification
A unit impulse traces each table entry back to a single coefficient, so it shows whether taps are misplaced or mirrored wrongly. A constant step and constant full-scale inputs of both signs drive every table address with all bits alike. This exposes carry and sign-plane errors that small values hide, and the most negative run is what separates subtraction of the top plane from addition. Seeded random signed samples then mix all addresses and bit patterns. On chosen samples the random phase also toggles in_valid with junk data while the engine is busy; any leak of that junk into the history shows up in later results.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  localparam int unsigned NTAP  = 32;
  localparam int unsigned HALF  = NTAP / 2;
  localparam int unsigned GRP   = 4;
  localparam int unsigned NPART = HALF / GRP;
  localparam int unsigned CW    = 12;

  // Coefficient of tap k; the upper half mirrors the lower half.
  function automatic logic signed [CW-1:0] coef(input int unsigned k);
    int unsigned m;
    m = (k < HALF) ? k : (NTAP - 1 - k);
    case (m)
      0:       coef = 12'sd4;
      1:       coef = 12'sd9;
      2:       coef = 12'sd13;
      3:       coef = 12'sd12;
      4:       coef = 12'sd5;
      5:       coef = -12'sd10;
      6:       coef = 12'sd30;
      7:       coef = -12'sd48;
      8:       coef = -12'sd55;
      9:       coef = -12'sd39;
      10:      coef = 12'sd3;
      11:      coef = 12'sd72;
      12:      coef = 12'sd158;
      13:      coef = 12'sd247;
      14:      coef = 12'sd321;
      default: coef = 12'sd362;
    endcase
  endfunction

  // Largest magnitude one bit-plane sum can take.
  function automatic int coef_abs_sum();
    int s;
    s = 0;
    for (int k = 0; k < int'(HALF); k++) begin
      s += (coef(k) < 0) ? -int'(coef(k)) : int'(coef(k));
    end
    return s;
  endfunction

endpackage

// File: rtl/dafir_tapline.sv
module dafir_tapline
  import dafir_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            shift_en,
  input  logic [DW-1:0]                   din,
  output logic [HALF-1:0][DW:0]           pre_o
);

  logic [NTAP-1:0][DW-1:0] line_q, line_d;

  // next state: newest sample enters at index 0
  always_comb begin
    line_d = line_q;
    if (shift_en) line_d = {line_q[NTAP-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else if (shift_en) line_q <= line_d;
  end

  // mirrored pair adder, one bit of growth
  always_comb begin
    for (int i = 0; i < int'(HALF); i++) begin
      pre_o[i] = $signed({line_q[i][DW-1], line_q[i]})
               + $signed({line_q[NTAP-1-i][DW-1], line_q[NTAP-1-i]});
    end
  end

  // R2: an accepted sample becomes the newest history entry
  a_r2_newest_sample: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> line_q[0] == $past(din));

  // R5: without a shift the history is untouched
  a_r5_history_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(line_q));

endmodule

// File: rtl/dafir_lut.sv
module dafir_lut
  import dafir_pkg::*;
#(
  parameter int PART = 0,
  parameter int SW   = 16
) (
  input  logic [GRP-1:0]        addr_i,
  output logic signed [SW-1:0]  val_o
);

  localparam int NENT = 1 << GRP;

  logic signed [SW-1:0] rom [NENT];

  // entry e holds the sum of the coefficients whose address bit is set
  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      rom[e] = '0;
      for (int j = 0; j < int'(GRP); j++) begin
        if (((e >> j) & 1) == 1) rom[e] = rom[e] + SW'(coef(PART * GRP + j));
      end
    end
  end

  assign val_o = rom[addr_i];

endmodule

// File: rtl/dafir_accum.sv
module dafir_accum #(
  parameter int SW = 16,
  parameter int PW = 13,
  parameter int OW = 29,
  parameter int BW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [BW-1:0]         in_bit,
  input  logic signed [SW-1:0]  in_sum,
  output logic                  out_vld,
  output logic signed [OW-1:0]  out_data
);

  logic signed [OW-1:0] acc_q, acc_d, out_q, out_d, term, base, nxt;
  logic                 last, vld_q, vld_d;

  always_comb begin
    last  = (in_bit == BW'(PW - 1));
    term  = OW'(in_sum) <<< in_bit;
    base  = (in_bit == '0) ? '0 : acc_q;
    nxt   = last ? (base - term) : (base + term);
    acc_d = in_vld ? nxt : acc_q;
    vld_d = in_vld && last;
    out_d = vld_d ? nxt : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_vld) acc_q <= acc_d;
      if (vld_d)  out_q <= out_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_data = out_q;

  // R6: the sign plane closes each result on the following edge
  a_r6_sign_plane_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_bit == BW'(PW - 1)) |=> out_vld);

  // R4: results are single-cycle pulses
  a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  // R4: the result holds between pulses
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_data));

endmodule

// File: rtl/dafir_top.sv
module dafir_top
  import dafir_pkg::*;
#(
  parameter int DW = 12,
  localparam int OW = 2 * DW + 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_data,
  output logic                 out_valid,
  output logic [OW-1:0]        out_data
);

  localparam int PW   = DW + 1;
  localparam int BW   = $clog2(PW);
  localparam int SW   = int'(CW) + $clog2(HALF);
  localparam int AW   = PW + int'(CW) + $clog2(HALF);
  localparam int SMAX = coef_abs_sum();
  localparam int LCW  = $clog2(PW + 5);

  // control and pipeline state
  logic                   busy_q, busy_d;
  logic                   load_q, load_d;
  logic                   run_q, run_d;
  logic [BW-1:0]          bit_q, bit_d;
  logic [HALF-1:0][PW-1:0] p_q, p_d;
  logic signed [SW-1:0]   sum_q, sum_d;
  logic [BW-1:0]          sbit_q, sbit_d;
  logic                   svld_q, svld_d;
  logic                   accept, last_plane;
  logic [HALF-1:0][DW:0]  pre;
  logic signed [SW-1:0]   part_v [NPART];
  logic signed [AW-1:0]   res;
  logic                   res_vld;

  assign accept     = in_valid && !busy_q;
  assign last_plane = svld_q && (sbit_q == BW'(PW - 1));

  dafir_tapline #(.DW(DW)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (in_data),
    .pre_o    (pre)
  );

  for (genvar g = 0; g < int'(NPART); g++) begin : g_part
    logic [GRP-1:0] addr;
    always_comb begin
      for (int j = 0; j < int'(GRP); j++) addr[j] = p_q[g * GRP + j][0];
    end
    dafir_lut #(.PART(g), .SW(SW)) u_lut (
      .addr_i (addr),
      .val_o  (part_v[g])
    );
  end

  // next-state logic
  always_comb begin
    busy_d = busy_q;
    if (accept)          busy_d = 1'b1;
    else if (last_plane) busy_d = 1'b0;

    load_d = accept;

    run_d = run_q;
    bit_d = bit_q;
    p_d   = p_q;
    if (load_q) begin
      run_d = 1'b1;
      bit_d = '0;
      p_d   = pre;
    end else if (run_q) begin
      run_d = (bit_q != BW'(PW - 1));
      bit_d = BW'(bit_q + 1'b1);
      for (int i = 0; i < int'(HALF); i++) p_d[i] = p_q[i] >> 1;
    end

    svld_d = run_q;
    sbit_d = bit_q;
    sum_d  = '0;
    for (int g = 0; g < int'(NPART); g++) sum_d = sum_d + part_v[g];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      load_q <= 1'b0;
      run_q  <= 1'b0;
      bit_q  <= '0;
      p_q    <= '0;
      sum_q  <= '0;
      sbit_q <= '0;
      svld_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      load_q <= load_d;
      svld_q <= svld_d;
      if (load_q || run_q) begin
        run_q <= run_d;
        bit_q <= bit_d;
        p_q   <= p_d;
      end
      if (run_q) begin
        sum_q  <= sum_d;
        sbit_q <= sbit_d;
      end
    end
  end

  dafir_accum #(.SW(SW), .PW(PW), .OW(AW), .BW(BW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (svld_q),
    .in_bit   (sbit_q),
    .in_sum   (sum_q),
    .out_vld  (res_vld),
    .out_data (res)
  );

  assign out_valid = res_vld;
  assign out_data  = OW'(res);

  // check-only latency counter, restarted by each accepted sample
  logic [LCW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         lat_q <= '0;
    else if (accept)                    lat_q <= LCW'(1);
    else if (lat_q != '0 && lat_q != LCW'(PW + 4)) lat_q <= LCW'(lat_q + 1'b1);
  end

  // R4: a result appears DW+3 edges after its accepting edge
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lat_q == LCW'(PW + 3));

  // R2: a plane sum never exceeds the total coefficient magnitude
  a_r2_plane_sum_range: assert property (@(posedge clk) disable iff (!rst_n)
    svld_q |-> (int'(sum_q) <= SMAX && int'(sum_q) >= -SMAX));

  // R2: bit-planes arrive in ascending order without gaps
  a_r2_plane_order: assert property (@(posedge clk) disable iff (!rst_n)
    (svld_q && sbit_q != BW'(PW - 1)) |=> (svld_q && sbit_q == BW'($past(sbit_q) + 1'b1)));

  // R8: the engine is free again when the result is shown
  a_r8_idle_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy_q);

endmodule

// File: tb/sim_dafir_top.sv
module sim_dafir_top;

  localparam int DW = 12;
  localparam int OW = 2 * DW + 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  longint hist [32];

  always #10 clk = ~clk;

  dafir_top #(.DW(DW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic longint hcoef(input int k);
    int lo [16] = '{4, 9, 13, 12, 5, -10, 30, -48, -55, -39, 3, 72, 158, 247, 321, 362};
    return longint'(lo[(k < 16) ? k : 31 - k]);
  endfunction

  function automatic longint model();
    longint s = 0;
    for (int k = 0; k < 32; k++) s += hcoef(k) * hist[k];
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns at the falling edge where the result is visible.
  task automatic send(input int x, input bit junk, input string tag);
    longint exp;
    bit early = 0;
    in_valid = 1'b1;
    in_data  = DW'(x);
    for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(DW'(x)));
    exp = model();
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k < 16 && out_valid) early = 1;
      if (k < 16) begin
        in_valid = junk;
        in_data  = DW'($urandom);
      end else begin
        in_valid = 1'b0;
      end
    end
    chk(!early, {tag, " R4 no early pulse"}, longint'(early), 0);
    chk(out_valid == 1'b1, {tag, " R4 pulse timing"}, longint'(out_valid), 1);
    chk(longint'($signed(out_data)) == exp, {tag, " value"},
        longint'($signed(out_data)), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 32; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(out_data == '0, "R1 out_data after reset", longint'($signed(out_data)), 0);

    // R3 / R1: impulse from a clean history
    send(1, 0, "R3 impulse");
    for (int i = 0; i < 33; i++) send(0, 0, "R3 impulse tail");

    // R8: constant step at minimum spacing
    for (int i = 0; i < 40; i++) send(100, 0, "R8 step");

    // R2: random signed samples
    for (int i = 0; i < 60; i++) send(int'($urandom % 4096) - 2048, 0, "R2 random");

    // R5: junk on in_valid while busy
    for (int i = 0; i < 12; i++) send(int'($urandom % 4096) - 2048, 1, "R5 busy junk");
    for (int i = 0; i < 4; i++) send(int'($urandom % 4096) - 2048, 0, "R5 after junk");

    // R6: most negative input
    for (int i = 0; i < 34; i++) send(-2048, 0, "R6 negative full scale");
    // R7: most positive input
    for (int i = 0; i < 34; i++) send(2047, 0, "R7 positive full scale");
    // R6: alternating extremes
    for (int i = 0; i < 12; i++) send((i % 2 == 0) ? -2048 : 2047, 0, "R6 alternating");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule